// File: doc/BRIEF.md
# 32-Source Interrupt Controller

The controller gathers 32 interrupt request lines, brings each one into the clock domain through a two-stage synchroniser, and records events in a status register. Each source has its own settings. One bit chooses edge or level sensing. One bit chooses the active sense: rising or high, or else falling or low. An enable bit gates the source. A routing bit sends it either to the critical processor interrupt or to the normal one.

Software reaches the registers over a plain word-addressed bus. The bus has a write strobe, a read strobe, a 4-bit address and 32-bit data. The status register clears when a one is written to a bit. A level source that is still active sets its bit again straight away, whether or not it is enabled. A separate masked view returns only the enabled pending sources.

After changing sense settings, software should clear the status register, because a change of polarity can look like an event.

Top module: `irq_ctrl32`

## Requirements
- R1: After reset the enable, routing, polarity and trigger registers read 0, and both interrupt outputs are low.
- R2: Input `irq_src_i[n]` is held in register bit 31−n of every per-source register, so source 0 is bit 31.
- R3: Word addresses: 0x0 status, 0x2 enable, 0x3 routing, 0x4 polarity, 0x5 trigger, 0x6 masked status. Any other address (0x1, 0x7, 0x8 and above) reads 0. Read data appears on `rdata_o` on the clock edge that samples `rd_i`, and it holds until the next read.
- R4: A trigger bit of 1 selects edge sensing. Polarity 1 then sets status on a rising edge of the synchronised input, and polarity 0 sets it on a falling edge. An edge in the other direction sets nothing.
- R5: A trigger bit of 0 selects level sensing. The status bit sets while the input equals the polarity bit (1 means active high, 0 means active low).
- R6: A write to address 0x0 clears each status bit written as 1 and leaves each bit written as 0 unchanged. A cleared edge source stays clear while its input is held.
- R7: Status bits latch whatever the enable bit says. A level source that is still active sets again in the same cycle as a clearing write, so its bit never reads 0.
- R8: A read of address 0x6 returns the status register ANDed with the enable register.
- R9: `irq_crit_o` is the OR of the masked status bits whose routing bit is 1. `irq_norm_o` is the OR of the masked status bits whose routing bit is 0. Both outputs are registered, and both are low when nothing is enabled.
- R10: An input change is in the status register three clock edges later and on the outputs four edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_src_i | input | 32 | Raw interrupt requests, index = source number |
| irq_crit_o | output | 1 | Critical interrupt request |
| irq_norm_o | output | 1 | Normal interrupt request |

## Verification
Each input change is made on a falling clock edge. Two synchroniser flops and the status flop then put the change into the status register at the third rising edge, and the output register brings it to the pins at the fourth. The bench therefore waits four rising edges and samples on the following falling edge. One directed case checks that the outputs are still low after the third edge and high after the fourth.

Read data is registered on the edge that samples `rd_i`. It is therefore read on the falling edge right after that edge, and a read always returns the status as it stood before that same edge.

// File: rtl/irq_ctrl32_pkg.sv
package irq_ctrl32_pkg;
  localparam int unsigned NSRC = 32;
  localparam int unsigned AW   = 4;
  localparam int unsigned DW   = NSRC;

  localparam logic [AW-1:0] A_STAT  = 4'h0;
  localparam logic [AW-1:0] A_EN    = 4'h2;
  localparam logic [AW-1:0] A_ROUTE = 4'h3;
  localparam logic [AW-1:0] A_POL   = 4'h4;
  localparam logic [AW-1:0] A_TRIG  = 4'h5;
  localparam logic [AW-1:0] A_MSTAT = 4'h6;
endpackage

// File: rtl/irq_ctrl32_sync.sv
module irq_ctrl32_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_ctrl32_detect.sv
module irq_ctrl32_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] trig_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] set_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic active;
    logic changed;
    assign active   = ~(sync_i[b] ^ pol_i[b]);
    assign changed  = sync_i[b] ^ prev_q[b];
    // edge: the new value is the active one; level: active now
    assign set_o[b] = trig_i[b] ? (changed & active) : active;
  end

  // R4: an edge-sensed source raises nothing while its input is steady
  a_r4_edge_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(sync_i) |-> ((set_o & trig_i) == '0));
endmodule

// File: rtl/irq_ctrl32_regs.sv
module irq_ctrl32_regs
  import irq_ctrl32_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] sts_o,
  output logic [DW-1:0] en_o,
  output logic [DW-1:0] route_o,
  output logic [DW-1:0] pol_o,
  output logic [DW-1:0] trig_o
);
  logic [DW-1:0] sts_q, en_q, route_q, pol_q, trig_q, rdata_q;
  logic [DW-1:0] clr, rd_mux;

  assign clr = (wr_i && addr_i == A_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= '0;
      en_q    <= '0;
      route_q <= '0;
      pol_q   <= '0;
      trig_q  <= '0;
    end else begin
      // set wins over clear so an active level source re-latches
      sts_q <= (sts_q & ~clr) | set_i;
      if (wr_i) begin
        case (addr_i)
          A_EN:    en_q    <= wdata_i;
          A_ROUTE: route_q <= wdata_i;
          A_POL:   pol_q   <= wdata_i;
          A_TRIG:  trig_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_STAT:  rd_mux = sts_q;
      A_EN:    rd_mux = en_q;
      A_ROUTE: rd_mux = route_q;
      A_POL:   rd_mux = pol_q;
      A_TRIG:  rd_mux = trig_q;
      A_MSTAT: rd_mux = sts_q & en_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign sts_o   = sts_q;
  assign en_o    = en_q;
  assign route_o = route_q;
  assign pol_o   = pol_q;
  assign trig_o  = trig_q;

  // R6: bits written as one are clear next cycle unless a new event arrived
  a_r6_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_STAT) |=> ((sts_q & $past(wdata_i) & ~$past(set_i)) == '0));

  // R7: every detected event is held in status on the next cycle
  a_r7_set_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> (($past(set_i) & ~sts_q) == '0));

  // R3: unmapped addresses read zero
  a_r3_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i == 4'h1 || addr_i > A_MSTAT)) |=> (rdata_o == '0));

  // R6: with no clearing write and no event, status holds
  a_r6_status_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_i && addr_i == A_STAT) && set_i == '0) |=> $stable(sts_q));
endmodule

// File: rtl/irq_ctrl32_out.sv
module irq_ctrl32_out #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sts_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] route_i,
  output logic         crit_o,
  output logic         norm_o
);
  logic [W-1:0] pend;
  logic crit_q, norm_q;

  assign pend = sts_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crit_q <= 1'b0;
      norm_q <= 1'b0;
    end else begin
      crit_q <= |(pend & route_i);
      norm_q <= |(pend & ~route_i);
    end
  end

  assign crit_o = crit_q;
  assign norm_o = norm_q;

  // R9: nothing enabled means both requests drop on the next cycle
  a_r9_quiet_when_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |=> (!crit_o && !norm_o));
endmodule

// File: rtl/irq_ctrl32.sv
module irq_ctrl32
  import irq_ctrl32_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [NSRC-1:0] irq_src_i,
  output logic          irq_crit_o,
  output logic          irq_norm_o
);
  logic [NSRC-1:0] src_bits, sync_bits, set_bits;
  logic [DW-1:0]   sts, en, route, pol, trig;

  // source n lives in register bit NSRC-1-n
  for (genvar n = 0; n < NSRC; n++) begin : g_rev
    assign src_bits[NSRC-1-n] = irq_src_i[n];
  end

  irq_ctrl32_sync #(.W(NSRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_bits),
    .q_o   (sync_bits)
  );

  irq_ctrl32_detect #(.W(NSRC)) u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_bits),
    .trig_i(trig),
    .pol_i (pol),
    .set_o (set_bits)
  );

  irq_ctrl32_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .set_i  (set_bits),
    .rdata_o(rdata_o),
    .sts_o  (sts),
    .en_o   (en),
    .route_o(route),
    .pol_o  (pol),
    .trig_o (trig)
  );

  irq_ctrl32_out #(.W(NSRC)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sts_i  (sts),
    .en_i   (en),
    .route_i(route),
    .crit_o (irq_crit_o),
    .norm_o (irq_norm_o)
  );
endmodule

// File: tb/irq_ctrl32_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl32_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] irq_src_i = '0;
  logic        irq_crit_o, irq_norm_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_ctrl32 dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_src_i(irq_src_i), .irq_crit_o(irq_crit_o), .irq_norm_o(irq_norm_o)
  );

  // fields: trig, pol, en, route, active mask (all in register-bit order)
  localparam int NV = 6;
  localparam logic [159:0] VEC [NV] = '{
    {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_00F0, 32'h00F0_00F0},
    {32'hFFFF_0000, 32'h00FF_00FF, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h8000_0001},
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hA5A5_A5A5},
    {32'hAAAA_AAAA, 32'h5555_5555, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h0F00_0000},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000}
  };

  function automatic logic [31:0] rev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_i = 1'b1; addr_i = a;
    @(posedge clk);
    @(negedge clk);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [31:0] reg_order);
    @(negedge clk);
    irq_src_i = rev(reg_order);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got %08h expected %08h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] trig, pol, en, route, act;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    settle();

    // R1 reset values
    reg_rd(4'h2, d); chk("R1 enable", d, 32'h0);
    reg_rd(4'h3, d); chk("R1 route", d, 32'h0);
    reg_rd(4'h4, d); chk("R1 polarity", d, 32'h0);
    reg_rd(4'h5, d); chk("R1 trigger", d, 32'h0);
    chk("R1 outputs", {30'd0, irq_crit_o, irq_norm_o}, 32'h0);
    // R5/R7: inputs low, default active-low level, disabled -> all latched
    reg_rd(4'h0, d); chk("R5 active-low default latches", d, 32'hFFFF_FFFF);
    reg_wr(4'h4, 32'hFFFF_FFFF);
    settle();
    reg_wr(4'h0, 32'hFFFF_FFFF);
    reg_rd(4'h0, d); chk("R6 clear all", d, 32'h0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      {trig, pol, en, route, act} = VEC[v];
      reg_wr(4'h5, trig);
      reg_wr(4'h4, pol);
      reg_wr(4'h2, en);
      reg_wr(4'h3, route);
      drive(~pol);
      settle();
      reg_wr(4'h0, 32'hFFFF_FFFF);
      reg_rd(4'h0, d); chk("R6 idle clear", d, 32'h0);
      drive(~pol ^ act);
      settle();
      reg_rd(4'h0, d); chk("R4/R5 status", d, act);
      reg_rd(4'h6, d); chk("R8 masked", d, act & en);
      chk("R9 crit", {31'd0, irq_crit_o}, {31'd0, |(act & en & route)});
      chk("R9 norm", {31'd0, irq_norm_o}, {31'd0, |(act & en & ~route)});
      drive(~pol);
      settle();
      reg_wr(4'h0, 32'hFFFF_FFFF);
      reg_rd(4'h0, d); chk("R6 clear after return", d, 32'h0);
    end

    // R7: level active-high source 3 (bit 28), disabled; clear does not stick
    reg_wr(4'h2, 32'h0);
    reg_wr(4'h5, 32'h0);
    reg_wr(4'h4, 32'hFFFF_FFFF);
    drive(32'h0);
    settle();
    reg_wr(4'h0, 32'hFFFF_FFFF);
    drive(32'h1000_0000);
    settle();
    reg_wr(4'h0, 32'h1000_0000);
    reg_rd(4'h0, d); chk("R7 level re-sets while active", d, 32'h1000_0000);
    reg_wr(4'h0, 32'h0);
    reg_rd(4'h0, d); chk("R6 write zero keeps", d, 32'h1000_0000);
    drive(32'h0);
    settle();
    reg_wr(4'h0, 32'hFFFF_FFFF);

    // R6: edge source held high clears and stays clear
    reg_wr(4'h5, 32'hFFFF_FFFF);
    settle();
    reg_wr(4'h0, 32'hFFFF_FFFF);
    drive(32'h1000_0000);
    settle();
    reg_rd(4'h0, d); chk("R4 rising edge sets", d, 32'h1000_0000);
    reg_wr(4'h0, 32'h1000_0000);
    settle();
    reg_rd(4'h0, d); chk("R6 edge stays clear while held", d, 32'h0);

    // R4: falling edge ignored with polarity 1
    drive(32'h0);
    settle();
    reg_rd(4'h0, d); chk("R4 opposite edge ignored", d, 32'h0);
    // polarity 0 edge: falling sets
    drive(32'h1000_0000);
    settle();
    reg_wr(4'h4, 32'h0);
    reg_wr(4'h0, 32'hFFFF_FFFF);
    drive(32'h0);
    settle();
    reg_rd(4'h0, d); chk("R4 falling edge sets", d, 32'h1000_0000);

    // R2: source 0 -> bit 31
    reg_wr(4'h4, 32'hFFFF_FFFF);
    irq_src_i = 32'h0;
    settle();
    reg_wr(4'h0, 32'hFFFF_FFFF);
    @(negedge clk); irq_src_i = 32'h0000_0001;
    settle();
    reg_rd(4'h0, d); chk("R2 source 0 in bit 31", d, 32'h8000_0000);

    // R3: unmapped addresses read zero while status nonzero
    reg_rd(4'h1, d); chk("R3 addr 1", d, 32'h0);
    reg_rd(4'h7, d); chk("R3 addr 7", d, 32'h0);
    reg_rd(4'h8, d); chk("R3 addr 8", d, 32'h0);
    reg_rd(4'hF, d); chk("R3 addr F", d, 32'h0);

    // R10: output latency (source 0 edge, normal route)
    reg_wr(4'h3, 32'h0);
    reg_wr(4'h2, 32'h8000_0000);
    @(negedge clk); irq_src_i = 32'h0;
    settle();
    reg_wr(4'h0, 32'hFFFF_FFFF);
    settle();
    chk("R10 idle before change", {31'd0, irq_norm_o}, 32'h0);
    @(negedge clk); irq_src_i = 32'h0000_0001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 not yet after 3 edges", {31'd0, irq_norm_o}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 output after 4 edges", {31'd0, irq_norm_o}, 32'h1);
    chk("R9 crit stays low", {31'd0, irq_crit_o}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule